// File: doc/BRIEF.md
# Compelled Sequence Controller

This block decides, for each signaling channel, when the multifrequency tone transmitter may send and which tone code it sends. Host transmit commands arrive on a shared port that names the channel. A receiver-side detector supplies a per-channel flag saying whether a far-end tone is present, together with its code. Per-channel configuration bits select the following:

- whether the channel is enabled;
- whether it sends forward or backward signals;
- whether the handshake runs automatically or under manual host control;
- whether the host is told when a far-end tone ends.

In automatic mode the channel follows a two-state compelled handshake. The link is either quiet (no far tone) or heard (far tone present). A forward channel may send only while quiet. A backward channel may send only while heard. A command written while sending is blocked is parked in a single-entry slot. The change of link state that unblocks sending releases it. Each arrival of a far tone produces a one-cycle report carrying the tone code. A departure produces an end report when that option is set. The output tone code is zero when the transmitter is silent.

Top module: `compelled_seq`

## Requirements
- R1: After reset every channel's `tx_code` is 0, `rpt_valid` is 0 and no command is held.
- R2: In manual mode (`cfg_auto`=0) an enabled channel's `tx_code` takes the command code one cycle after the command and changes at no other time, whatever the detector shows.
- R3: In automatic forward mode (`cfg_forward`=1) a command issued while `det_valid` is 0 drives `tx_code` on the next cycle. While `det_valid` is 1, `tx_code` is forced to 0 and commands are held.
- R4: In automatic forward mode, in the cycle after `det_valid` falls, a held command appears on `tx_code` and the slot is then empty.
- R5: In automatic backward mode (`cfg_forward`=0), `tx_code` is forced to 0 and commands are held while `det_valid` is 0. A command issued while `det_valid` is 1 drives `tx_code` on the next cycle.
- R6: In automatic backward mode, in the cycle after `det_valid` rises, a held command appears on `tx_code`.
- R7: A command issued in the same cycle as a detector change is judged against the link state that change produces.
- R8: Only one command is held per channel. A later held command replaces an earlier one, and the released code is the latest.
- R9: One cycle after `det_valid` rises on an enabled channel, `rpt_valid` pulses for one cycle with `rpt_end`=0 and `rpt_code` equal to the `det_code` of the rising cycle.
- R10: One cycle after `det_valid` falls, `rpt_valid` pulses with `rpt_end`=1 and `rpt_code`=0 only if `cfg_eod`=1. With `cfg_eod`=0 no report is given.
- R11: While `cfg_enable`=0 a channel ignores commands and the detector: `tx_code` holds its value, no report is given, the link state is frozen and any held command is discarded.
- R12: A code of 0 means tone off. The value of `cmd_chan` (0 to NUM_CH-1) selects the channel a command reaches, and other channels are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | NUM_CH | Per-channel enable |
| cfg_forward | input | NUM_CH | 1 = forward signaling, 0 = backward |
| cfg_auto | input | NUM_CH | 1 = automatic compelled handshake, 0 = manual |
| cfg_eod | input | NUM_CH | 1 = report the end of a far tone |
| cmd_valid | input | 1 | Host transmit command strobe |
| cmd_chan | input | CH_W | Channel addressed by the command |
| cmd_code | input | CODE_W | Tone code to send, 0 = off |
| det_valid | input | NUM_CH | Far tone present, per channel |
| det_code | input | NUM_CH*CODE_W | Detected tone code, per channel |
| tx_code | output | NUM_CH*CODE_W | Active transmit code, per channel, 0 = silent |
| rpt_valid | output | NUM_CH | Report strobe, per channel |
| rpt_end | output | NUM_CH | Report is an end-of-tone report |
| rpt_code | output | NUM_CH*CODE_W | Reported tone code |

## Verification
The assertions assume that the configuration bits of a channel are held steady while a command or detector transition for that channel is in flight. They also assume that `det_code` is meaningful in the cycle in which `det_valid` rises. The directed stimulus changes configuration only between scenarios, at a falling edge. It pulses `cmd_valid` for exactly one cycle and presents the tone code together with the rising `det_valid`. Commands and detector changes are placed in the same cycle only where the ordering rule itself is under test.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    // Link condition seen from one channel's receiver.
    typedef enum logic {
        LINK_QUIET = 1'b0,
        LINK_HEARD = 1'b1
    } link_state_e;

    // Per-channel configuration bundle.
    typedef struct packed {
        logic enable;
        logic forward;
        logic autom;
        logic eod;
    } chan_cfg_t;

    // Link transitions taken at the coming edge.
    typedef struct packed {
        logic to_heard;
        logic to_quiet;
    } link_evt_t;

    // Whether the transmitter may send in a given link state.
    function automatic logic send_allowed(input logic autom, input logic forward,
                                          input link_state_e st);
        if (!autom) begin
            return 1'b1;
        end
        return forward ? (st == LINK_QUIET) : (st == LINK_HEARD);
    endfunction

    // Whether a transition opens the gate for the transmitter.
    function automatic logic gate_opens(input logic autom, input logic forward,
                                        input link_evt_t ev);
        if (!autom) begin
            return 1'b0;
        end
        return forward ? ev.to_quiet : ev.to_heard;
    endfunction

endpackage

// File: rtl/cseq_link_tracker.sv
module cseq_link_tracker
    import cseq_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              eod,
    input  logic              det_valid,
    input  logic [CODE_W-1:0] det_code,
    output link_state_e       state_nxt,
    output link_evt_t         evt,
    output logic              rpt_valid,
    output logic              rpt_end,
    output logic [CODE_W-1:0] rpt_code
);

    link_state_e state_q;

    // A disabled channel keeps its link state frozen.
    always_comb begin
        state_nxt = state_q;
        if (enable) begin
            state_nxt = det_valid ? LINK_HEARD : LINK_QUIET;
        end
    end

    always_comb begin
        evt.to_heard = (state_q == LINK_QUIET) && (state_nxt == LINK_HEARD);
        evt.to_quiet = (state_q == LINK_HEARD) && (state_nxt == LINK_QUIET);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LINK_QUIET;
            rpt_valid <= 1'b0;
            rpt_end   <= 1'b0;
            rpt_code  <= '0;
        end else begin
            state_q   <= state_nxt;
            rpt_valid <= evt.to_heard || (evt.to_quiet && eod);
            rpt_end   <= evt.to_quiet && eod;
            rpt_code  <= evt.to_heard ? det_code : '0;
        end
    end

    AST_END_NEEDS_EOD: assert property (@(posedge clk) disable iff (rst)
        rpt_valid && rpt_end |-> $past(eod)); // R10

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !rpt_valid); // R11

    AST_ARRIVAL_CODE: assert property (@(posedge clk) disable iff (rst)
        rpt_valid && !rpt_end |-> rpt_code == $past(det_code)); // R9

endmodule

// File: rtl/cseq_pending_slot.sv
module cseq_pending_slot #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic              take,
    output logic              pend_valid,
    output logic [CODE_W-1:0] pend_code
);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pend_valid <= 1'b0;
            pend_code  <= '0;
        end else if (load) begin
            pend_valid <= 1'b1;
            pend_code  <= load_code;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end

    AST_PEND_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pend_valid); // R11

    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        enable && take && !load |=> !pend_valid); // R4

    AST_NEWEST_KEPT: assert property (@(posedge clk) disable iff (rst)
        enable && load |=> pend_valid && pend_code == $past(load_code)); // R8

endmodule

// File: rtl/cseq_tx_ctrl.sv
module cseq_tx_ctrl
    import cseq_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              forward,
    input  logic              autom,
    input  logic              cmd_hit,
    input  logic [CODE_W-1:0] cmd_code,
    input  link_state_e       state_nxt,
    input  link_evt_t         evt,
    input  logic              pend_valid,
    input  logic [CODE_W-1:0] pend_code,
    output logic [CODE_W-1:0] tx_code,
    output logic              pend_load,
    output logic              pend_take
);

    logic [CODE_W-1:0] tx_q;
    logic [CODE_W-1:0] tx_d;
    logic              allow_nxt;
    logic              opens;

    assign allow_nxt = send_allowed(autom, forward, state_nxt);
    assign opens     = gate_opens(autom, forward, evt);

    // Commands are judged against the state the link holds after this edge.
    always_comb begin
        tx_d      = tx_q;
        pend_load = 1'b0;
        pend_take = 1'b0;
        if (enable) begin
            if (!allow_nxt) begin
                tx_d      = '0;
                pend_load = cmd_hit;
            end else if (cmd_hit) begin
                tx_d      = cmd_code;
                pend_take = pend_valid;
            end else if (opens && pend_valid) begin
                tx_d      = pend_code;
                pend_take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_code = tx_q;

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(tx_q)); // R11

    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        enable && !autom && !cmd_hit |=> $stable(tx_q)); // R2

    AST_RELEASE_CODE: assert property (@(posedge clk) disable iff (rst)
        pend_take && !cmd_hit |=> tx_q == $past(pend_code)); // R4

endmodule

// File: rtl/compelled_seq.sv
module compelled_seq
    import cseq_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        cfg_enable,
    input  logic [NUM_CH-1:0]        cfg_forward,
    input  logic [NUM_CH-1:0]        cfg_auto,
    input  logic [NUM_CH-1:0]        cfg_eod,
    input  logic                     cmd_valid,
    input  logic [CH_W-1:0]          cmd_chan,
    input  logic [CODE_W-1:0]        cmd_code,
    input  logic [NUM_CH-1:0]        det_valid,
    input  logic [NUM_CH*CODE_W-1:0] det_code,
    output logic [NUM_CH*CODE_W-1:0] tx_code,
    output logic [NUM_CH-1:0]        rpt_valid,
    output logic [NUM_CH-1:0]        rpt_end,
    output logic [NUM_CH*CODE_W-1:0] rpt_code
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_cfg_t         cfg;
        logic              cmd_hit;
        link_state_e       state_nxt;
        link_evt_t         evt;
        logic              pend_valid;
        logic [CODE_W-1:0] pend_code;
        logic              pend_load;
        logic              pend_take;

        assign cfg.enable  = cfg_enable[i];
        assign cfg.forward = cfg_forward[i];
        assign cfg.autom   = cfg_auto[i];
        assign cfg.eod     = cfg_eod[i];
        assign cmd_hit     = cmd_valid && (cmd_chan == CH_W'(i));

        cseq_link_tracker #(.CODE_W(CODE_W)) u_link (
            .clk       (clk),
            .rst       (rst),
            .enable    (cfg.enable),
            .eod       (cfg.eod),
            .det_valid (det_valid[i]),
            .det_code  (det_code[i*CODE_W +: CODE_W]),
            .state_nxt (state_nxt),
            .evt       (evt),
            .rpt_valid (rpt_valid[i]),
            .rpt_end   (rpt_end[i]),
            .rpt_code  (rpt_code[i*CODE_W +: CODE_W])
        );

        cseq_pending_slot #(.CODE_W(CODE_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .enable     (cfg.enable),
            .load       (pend_load),
            .load_code  (cmd_code),
            .take       (pend_take),
            .pend_valid (pend_valid),
            .pend_code  (pend_code)
        );

        cseq_tx_ctrl #(.CODE_W(CODE_W)) u_tx (
            .clk        (clk),
            .rst        (rst),
            .enable     (cfg.enable),
            .forward    (cfg.forward),
            .autom      (cfg.autom),
            .cmd_hit    (cmd_hit),
            .cmd_code   (cmd_code),
            .state_nxt  (state_nxt),
            .evt        (evt),
            .pend_valid (pend_valid),
            .pend_code  (pend_code),
            .tx_code    (tx_code[i*CODE_W +: CODE_W]),
            .pend_load  (pend_load),
            .pend_take  (pend_take)
        );

        AST_FWD_FORCED_OFF: assert property (@(posedge clk) disable iff (rst)
            cfg_enable[i] && cfg_auto[i] && cfg_forward[i] && det_valid[i]
            |=> tx_code[i*CODE_W +: CODE_W] == '0); // R3

        AST_BWD_FORCED_OFF: assert property (@(posedge clk) disable iff (rst)
            cfg_enable[i] && cfg_auto[i] && !cfg_forward[i] && !det_valid[i]
            |=> tx_code[i*CODE_W +: CODE_W] == '0); // R5
    end

endmodule

// File: tb/sim_compelled_seq.sv
module sim_compelled_seq;

    localparam int NUM_CH = 2;
    localparam int CODE_W = 4;
    localparam int CH_W   = 1;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [NUM_CH-1:0]        cfg_enable = '0;
    logic [NUM_CH-1:0]        cfg_forward = '0;
    logic [NUM_CH-1:0]        cfg_auto = '0;
    logic [NUM_CH-1:0]        cfg_eod = '0;
    logic                     cmd_valid = 1'b0;
    logic [CH_W-1:0]          cmd_chan = '0;
    logic [CODE_W-1:0]        cmd_code = '0;
    logic [NUM_CH-1:0]        det_valid = '0;
    logic [NUM_CH*CODE_W-1:0] det_code = '0;
    logic [NUM_CH*CODE_W-1:0] tx_code;
    logic [NUM_CH-1:0]        rpt_valid;
    logic [NUM_CH-1:0]        rpt_end;
    logic [NUM_CH*CODE_W-1:0] rpt_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    compelled_seq #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u0 (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_enable), .cfg_forward(cfg_forward),
        .cfg_auto(cfg_auto), .cfg_eod(cfg_eod),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_code(cmd_code),
        .det_valid(det_valid), .det_code(det_code),
        .tx_code(tx_code), .rpt_valid(rpt_valid),
        .rpt_end(rpt_end), .rpt_code(rpt_code)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int tx_of(input int ch);
        return int'(tx_code[ch*CODE_W +: CODE_W]);
    endfunction

    function automatic int rcode_of(input int ch);
        return int'(rpt_code[ch*CODE_W +: CODE_W]);
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic send(input int ch, input int code);
        cmd_valid = 1'b1;
        cmd_chan  = CH_W'(ch);
        cmd_code  = CODE_W'(code);
        cyc();
        cmd_valid = 1'b0;
    endtask

    task automatic detect(input int ch, input logic on, input int code);
        det_valid[ch] = on;
        det_code[ch*CODE_W +: CODE_W] = CODE_W'(code);
        cyc();
    endtask

    task automatic set_cfg(input int ch, input logic en, input logic fwd,
                           input logic aut, input logic eod);
        cfg_enable[ch]  = en;
        cfg_forward[ch] = fwd;
        cfg_auto[ch]    = aut;
        cfg_eod[ch]     = eod;
    endtask

    task automatic t_reset();
        chk("R1 tx ch0", tx_of(0), 0);
        chk("R1 tx ch1", tx_of(1), 0);
        chk("R1 rpt_valid", int'(rpt_valid), 0);
    endtask

    task automatic t_manual();
        set_cfg(0, 1, 1, 0, 1);
        detect(0, 1, 5);
        chk("R9 arrival strobe", int'(rpt_valid[0]), 1);
        chk("R9 arrival code", rcode_of(0), 5);
        chk("R9 arrival not end", int'(rpt_end[0]), 0);
        send(0, 3);
        chk("R2 manual send under far tone", tx_of(0), 3);
        detect(0, 0, 0);
        chk("R10 end strobe", int'(rpt_valid[0]), 1);
        chk("R10 end flag", int'(rpt_end[0]), 1);
        chk("R10 end code zero", rcode_of(0), 0);
        chk("R2 manual hold on far change", tx_of(0), 3);
        send(0, 0);
        chk("R12 zero code silences", tx_of(0), 0);
    endtask

    task automatic t_forward_auto();
        set_cfg(0, 1, 1, 1, 1);
        send(0, 7);
        chk("R3 fwd quiet send", tx_of(0), 7);
        detect(0, 1, 2);
        chk("R3 fwd heard forced off", tx_of(0), 0);
        send(0, 9);
        chk("R3 fwd command held", tx_of(0), 0);
        send(0, 4);
        chk("R8 replacement held", tx_of(0), 0);
        detect(0, 0, 0);
        chk("R4 R8 release newest", tx_of(0), 4);
        detect(0, 1, 2);
        chk("R3 fwd forced off again", tx_of(0), 0);
        detect(0, 0, 0);
        chk("R4 slot emptied", tx_of(0), 0);
    endtask

    task automatic t_backward_auto();
        set_cfg(0, 1, 1, 0, 1);
        send(0, 2);
        set_cfg(1, 1, 0, 1, 0);
        send(1, 6);
        chk("R5 bwd quiet held", tx_of(1), 0);
        detect(1, 1, 1);
        chk("R6 bwd release on arrival", tx_of(1), 6);
        chk("R9 ch1 arrival code", rcode_of(1), 1);
        send(1, 11);
        chk("R5 bwd heard send", tx_of(1), 11);
        detect(1, 0, 0);
        chk("R5 bwd forced off", tx_of(1), 0);
        chk("R10 no end report without option", int'(rpt_valid[1]), 0);
        chk("R12 other channel untouched", tx_of(0), 2);
    endtask

    task automatic t_same_cycle();
        det_valid[1] = 1'b1;
        det_code[1*CODE_W +: CODE_W] = CODE_W'(3);
        send(1, 13);
        chk("R7 command judged on new state", tx_of(1), 13);
        detect(1, 0, 0);
        chk("R7 bwd off after departure", tx_of(1), 0);
    endtask

    task automatic t_disabled();
        set_cfg(0, 0, 1, 0, 1);
        send(0, 8);
        chk("R11 disabled ignores command", tx_of(0), 2);
        detect(0, 1, 5);
        chk("R11 disabled no report", int'(rpt_valid[0]), 0);
        chk("R11 disabled tx held", tx_of(0), 2);
        detect(0, 0, 0);
        set_cfg(0, 1, 1, 1, 1);
        detect(0, 1, 5);
        chk("R3 enable under far tone forces off", tx_of(0), 0);
        send(0, 9);
        set_cfg(0, 0, 1, 1, 1);
        detect(0, 0, 0);
        chk("R11 tx held while disabled", tx_of(0), 0);
        set_cfg(0, 1, 1, 1, 1);
        cyc();
        chk("R11 held command discarded", tx_of(0), 0);
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_manual();
        t_forward_auto();
        t_backward_auto();
        t_same_cycle();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule